// File: doc/BRIEF.md
# Four-Tap Bit-Serial FIR Filter

This block is a direct-form finite impulse response filter with four taps. It computes `y[n] = a0*x[n] + a1*x[n-1] + a2*x[n-2] + a3*x[n-3]` over unsigned operands, one bit per clock. Samples enter on a single wire as fixed-length frames, least significant bit first. A strobe marks the first bit of each frame. Each frame carries `F = 2W+2` bit slots, where `W` is the width of a sample and of a coefficient. Only the low `W` slots carry sample data, and the block forces the remaining slots to zero. With that padding, the full four-term sum fits in one frame.

Each tap is a serial-by-parallel multiplier. The coefficient is the parallel operand, and the sample bit stream is the serial operand. A tree of one-bit adders with registered carries sums the four product streams. Three shift registers, each one frame long, hold the older samples. Together they form a chain that advances only during frame slots, so idle cycles between frames are allowed. The result leaves on one wire as a frame of the same length, with its own first-bit strobe and a valid flag.

The four coefficients come in on one parallel bus. A load strobe captures them, but only while no frame is in progress.

Top module: `bsfir4`

## Requirements
- R1: A frame starts in the cycle `x_start` is high and occupies that cycle and the following `F-1` cycles (`F = 2W+2`). Input bit k of the frame is the bit of weight 2^k. The output frame has the same format and trails the input frame by exactly one cycle: `y_start` is high with output bit 0, and `y_valid` is high for exactly those `F` cycles.
- R2: Each output frame equals `a0*x[n] + a1*x[n-1] + a2*x[n-2] + a3*x[n-3]`, taken as unsigned integers, where `x[n]` is the sample of the frame just received and `x[n-k]` is the sample of the k-th previous frame.
- R3: Input bits in frame slots W through F-1 are ignored and treated as zero, both for the current output and for the stored history.
- R4: After reset, the history holds zeros. The first output frame after reset is `a0*x[n]`, and the second is `a0*x[n] + a1*x[n-1]`.
- R5: A `coef_load` pulse in a cycle with no frame in progress captures `coef_bus` as the new coefficients. Tap k takes bits `[k*W +: W]`. The new values apply from the next frame onward.
- R6: A `coef_load` pulse during a frame, including the cycle in which `x_start` is high, has no effect.
- R7: Frames may follow back to back or be separated by any number of idle cycles. The history advances once per frame, never on idle cycles.
- R8: Outside an output frame, `y_valid` and `y_bit` are low.
- R9: Reset sets all three outputs low and all coefficients to zero, so every frame before the first load produces a zero result.
- R10: When all samples and all coefficients are at their maximum value `2^W-1`, the output equals `4*(2^W-1)^2` exactly, with no loss of the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_start | input | 1 | High on the first (least significant) bit of an input frame |
| x_bit | input | 1 | Serial sample bit |
| coef_load | input | 1 | Capture the coefficient bus while idle |
| coef_bus | input | 4*W | Coefficients; tap k at bits [k*W +: W] |
| y_start | output | 1 | High on the first bit of an output frame |
| y_valid | output | 1 | High during the output frame slots |
| y_bit | output | 1 | Serial result bit, least significant first |

## Verification
Output bit k is due one cycle after input bit k. `y_start` is due one cycle after `x_start`, and a coefficient load takes effect at the edge that samples it. The bench drives inputs on the falling edge. A separate monitor samples the outputs just after each rising edge, collects every bit flagged by `y_valid`, and compares each finished frame with the next entry of a queue of expected sums. Because of this, back-to-back frames and frames with gaps of any length are checked the same way, without per-frame timing assumptions. Each expected sum is computed arithmetically from a bench-side history of samples and coefficients.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;

    localparam int NTAPS = 4;

    // slots per frame: product needs 2W bits, four-term sum two more
    function automatic int frame_bits(input int w);
        return 2 * w + 2;
    endfunction

    function automatic int slot_cnt_bits(input int w);
        return $clog2(2 * w + 2);
    endfunction

    typedef struct packed {
        logic live;     // cycle belongs to a frame
        logic first;    // slot 0 of the frame
        logic data_ok;  // slot index below W (sample bit, not padding)
    } slot_t;

endpackage

// File: rtl/bsfir_framer.sv
module bsfir_framer
    import bsfir_pkg::*;
#(
    parameter int W = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  x_start,
    output slot_t slot
);
    localparam int F  = frame_bits(W);
    localparam int CW = slot_cnt_bits(W);

    logic [CW-1:0] cnt;
    logic          run;
    logic [CW-1:0] idx;

    always_comb begin
        idx          = x_start ? '0 : cnt;
        slot.live    = x_start | run;
        slot.first   = x_start;
        slot.data_ok = (x_start | run) && (idx < CW'(W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (x_start) begin
            run <= 1'b1;
            cnt <= CW'(1);
        end else if (run) begin
            if (cnt == CW'(F - 1)) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/bsfir_sp_mult.sv
module bsfir_sp_mult #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         live,
    input  logic         first,
    input  logic         x_in,
    input  logic [W-1:0] coef,
    output logic         p_bit
);
    logic [W-1:0] acc;
    logic [W-1:0] base;
    logic [W:0]   tmp;

    always_comb begin
        base  = first ? '0 : acc;
        tmp   = {1'b0, base} + (x_in ? {1'b0, coef} : '0);
        p_bit = tmp[0];
    end

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (live) acc <= tmp[W:1];
    end
endmodule

// File: rtl/bsfir_serial_add.sv
module bsfir_serial_add (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic first,
    input  logic a,
    input  logic b,
    output logic s
);
    logic cy;
    logic cin;

    always_comb begin
        cin = first ? 1'b0 : cy;
        s   = a ^ b ^ cin;
    end

    always_ff @(posedge clk) begin
        if (rst)       cy <= 1'b0;
        else if (live) cy <= (a & b) | (a & cin) | (b & cin);
    end
endmodule

// File: rtl/bsfir_delay.sv
module bsfir_delay #(
    parameter int F = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic din,
    output logic dout
);
    logic [F-1:0] sr;

    assign dout = sr[0];

    always_ff @(posedge clk) begin
        if (rst)       sr <= '0;
        else if (live) sr <= {din, sr[F-1:1]};
    end
endmodule

// File: rtl/bsfir4.sv
module bsfir4
    import bsfir_pkg::*;
#(
    parameter int W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               x_start,
    input  logic               x_bit,
    input  logic               coef_load,
    input  logic [NTAPS*W-1:0] coef_bus,
    output logic               y_start,
    output logic               y_valid,
    output logic               y_bit
);
    localparam int F = frame_bits(W);

    slot_t              slot;
    logic               busy;
    logic               tap_bit  [NTAPS];
    logic               prod_bit [NTAPS];
    logic               pair_sum [NTAPS/2];
    logic               sum_bit;
    logic [NTAPS*W-1:0] coef_flat;

    bsfir_framer #(.W(W)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .x_start (x_start),
        .slot    (slot)
    );

    assign busy       = slot.live;
    assign tap_bit[0] = slot.data_ok & x_bit;

    for (genvar d = 1; d < NTAPS; d++) begin : g_delay
        bsfir_delay #(.F(F)) u_dly (
            .clk  (clk),
            .rst  (rst),
            .live (slot.live),
            .din  (tap_bit[d-1]),
            .dout (tap_bit[d])
        );
    end

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        logic [W-1:0] coef_q;

        always_ff @(posedge clk) begin
            if (rst)                   coef_q <= '0;
            else if (coef_load && !busy) coef_q <= coef_bus[t*W +: W];
        end

        assign coef_flat[t*W +: W] = coef_q;

        bsfir_sp_mult #(.W(W)) u_mul (
            .clk   (clk),
            .rst   (rst),
            .live  (slot.live),
            .first (slot.first),
            .x_in  (tap_bit[t]),
            .coef  (coef_q),
            .p_bit (prod_bit[t])
        );
    end

    for (genvar p = 0; p < NTAPS/2; p++) begin : g_pair
        bsfir_serial_add u_add (
            .clk   (clk),
            .rst   (rst),
            .live  (slot.live),
            .first (slot.first),
            .a     (prod_bit[2*p]),
            .b     (prod_bit[2*p+1]),
            .s     (pair_sum[p])
        );
    end

    bsfir_serial_add u_add_final (
        .clk   (clk),
        .rst   (rst),
        .live  (slot.live),
        .first (slot.first),
        .a     (pair_sum[0]),
        .b     (pair_sum[1]),
        .s     (sum_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_start <= 1'b0;
            y_valid <= 1'b0;
            y_bit   <= 1'b0;
        end else begin
            y_start <= slot.first;
            y_valid <= slot.live;
            y_bit   <= slot.live & sum_bit;
        end
    end
endmodule

// File: rtl/bsfir4_chk.sv
module bsfir4_chk #(
    parameter int W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             x_start,
    input logic             busy,
    input logic             coef_load,
    input logic [4*W-1:0]   coef_bus,
    input logic [4*W-1:0]   coef_flat,
    input logic             y_start,
    input logic             y_valid,
    input logic             y_bit
);
    assert_start_lag_R1: assert property (@(posedge clk) disable iff (rst)
        x_start |=> y_start);

    assert_start_inside_R1: assert property (@(posedge clk) disable iff (rst)
        y_start |-> y_valid);

    assert_valid_lag_R1: assert property (@(posedge clk) disable iff (rst)
        busy |=> y_valid);

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (!y_valid && !y_bit));

    assert_load_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (coef_load && !busy) |=> (coef_flat == $past(coef_bus)));

    assert_load_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (coef_load && busy) |=> $stable(coef_flat));
endmodule

bind bsfir4 bsfir4_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .x_start   (x_start),
    .busy      (busy),
    .coef_load (coef_load),
    .coef_bus  (coef_bus),
    .coef_flat (coef_flat),
    .y_start   (y_start),
    .y_valid   (y_valid),
    .y_bit     (y_bit)
);

// File: tb/bsfir4_bench.sv
module bsfir4_bench;
    localparam int W = 4;
    localparam int F = 2 * W + 2;
    localparam int MAXV = (1 << W) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           x_start = 1'b0;
    logic           x_bit = 1'b0;
    logic           coef_load = 1'b0;
    logic [4*W-1:0] coef_bus = '0;
    logic           y_start;
    logic           y_valid;
    logic           y_bit;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int unsigned    c_mdl [4];
    int unsigned    h_mdl [4];
    logic [F-1:0]   exp_q [$];
    string          tag_q [$];

    logic [F-1:0]   col;
    int             ncol = 0;

    always #4 clk = ~clk;

    bsfir4 #(.W(W)) u_bsfir4 (
        .clk       (clk),
        .rst       (rst),
        .x_start   (x_start),
        .x_bit     (x_bit),
        .coef_load (coef_load),
        .coef_bus  (coef_bus),
        .y_start   (y_start),
        .y_valid   (y_valid),
        .y_bit     (y_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // output monitor: samples just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst) begin
            ncol = 0;
        end else if (y_valid) begin
            if (ncol == 0) check(y_start == 1'b1, "R1 y_start on bit0", int'(y_start), 1);
            else if (y_start) check(1'b0, "R1 y_start mid-frame", 1, 0);
            col[ncol] = y_bit;
            ncol++;
            if (ncol == F) begin
                ncol = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected output frame", int'(col), -1);
                end else begin
                    logic [F-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(col == e, t, int'(col), int'(e));
                end
            end
        end else begin
            if (ncol != 0) begin
                check(1'b0, "R1 frame cut short", ncol, F);
                ncol = 0;
            end
            if (y_bit) check(1'b0, "R8 y_bit outside frame", 1, 0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            x_start   = 1'b0;
            x_bit     = 1'b0;
            coef_load = 1'b0;
        end
    endtask

    task automatic load(input int unsigned a0, input int unsigned a1,
                        input int unsigned a2, input int unsigned a3);
        @(negedge clk);
        x_start   = 1'b0;
        x_bit     = 1'b0;
        coef_bus  = {W'(a3), W'(a2), W'(a1), W'(a0)};
        coef_load = 1'b1;
        c_mdl[0] = a0; c_mdl[1] = a1; c_mdl[2] = a2; c_mdl[3] = a3;
        @(negedge clk);
        coef_load = 1'b0;
    endtask

    // pad: value driven on padding slots; load_at: slot of an illegal load, -1 none
    task automatic send(input int unsigned x, input bit pad, input int load_at, input string tag);
        int unsigned s;
        h_mdl[3] = h_mdl[2]; h_mdl[2] = h_mdl[1]; h_mdl[1] = h_mdl[0];
        h_mdl[0] = x & MAXV;
        s = 0;
        for (int k = 0; k < 4; k++) s += c_mdl[k] * h_mdl[k];
        exp_q.push_back(F'(s));
        tag_q.push_back(tag);
        for (int k = 0; k < F; k++) begin
            @(negedge clk);
            x_start   = (k == 0);
            x_bit     = (k < W) ? x[k] : pad;
            coef_load = (k == load_at);
            if (k == load_at) coef_bus = ~coef_bus ^ {4*W{1'b1}} ^ 16'h5A3C;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x_start = 1'b0; x_bit = 1'b0; coef_load = 1'b0;
        for (int k = 0; k < 4; k++) begin c_mdl[k] = 0; h_mdl[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin c_mdl[k] = 0; h_mdl[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(y_valid == 1'b0, "R9 y_valid after reset", int'(y_valid), 0);
        check(y_start == 1'b0, "R9 y_start after reset", int'(y_start), 0);
        check(y_bit == 1'b0, "R9 y_bit after reset", int'(y_bit), 0);

        // coefficients are zero until loaded
        send(MAXV, 1'b0, -1, "R9 zero coefficients");
        idle(3);

        // sweep all sample values back to back
        load(3, 5, 7, 11);
        send(9, 1'b0, -1, "R5 first frame after load");
        for (int x = 0; x <= MAXV; x++) send(x, 1'b0, -1, "R2 sweep back-to-back R7");
        idle(2);

        // full-scale operands
        load(MAXV, MAXV, MAXV, MAXV);
        for (int i = 0; i < 5; i++) send(MAXV, 1'b1, -1, "R10 full scale");
        idle(1);

        // random coefficient sets, padding noise and gaps
        for (int s = 0; s < 6; s++) begin
            load($urandom_range(MAXV), $urandom_range(MAXV),
                 $urandom_range(MAXV), $urandom_range(MAXV));
            for (int i = 0; i < 10; i++) begin
                bit p;
                p = 1'($urandom_range(1));
                send($urandom_range(MAXV), p, -1, p ? "R3 padding ignored" : "R2 random");
                idle($urandom_range(3));
            end
            idle(1);
        end

        // loads attempted during frames
        load(1, 2, 3, 4);
        send(7, 1'b0, 0, "R6 load on start slot");
        send(12, 1'b0, 5, "R6 load mid-frame");
        send(3, 1'b1, F - 1, "R6 load on last slot");
        send(14, 1'b0, -1, "R6 after blocked loads");
        idle(4);

        // history cleared by reset
        do_reset();
        load(2, 9, 4, 13);
        send(10, 1'b0, -1, "R4 first frame after reset");
        send(6, 1'b0, -1, "R4 second frame after reset");
        idle(30);
        send(5, 1'b0, -1, "R7 long gap");
        idle(F + 4);

        check(exp_q.size() == 0, "R1 all frames emitted", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule